// File: doc/BRIEF.md
# Control-Bus Frame Transmit Retry Controller

This block drives a bit-level transmitter on a consumer-electronics control bus and sequences the sending of one frame of up to 16 bytes. Software fills a frame buffer, writes the byte count (header byte included) and a retry limit, and then sets the enable bit. Each attempt starts with a one-cycle start pulse to the transmitter, followed by the frame bytes on a valid/ready byte stream. The transmitter then returns one result for the attempt: acknowledged, not acknowledged, arbitration lost, or low-drive error.

Failed attempts are retried in hardware until the programmed limit is reached. NACK and low-drive results are counted in two packed 4-bit fields. The operation ends in one of three sticky outcomes: ready, arbitration lost, or retry timeout. Each outcome sets a write-one-to-clear flag and clears the enable bit.

Register map (address: content): 0x00-0x0F frame bytes; 0x10 length; 0x11 retry limit; 0x12 enable; 0x13 interrupt flags; 0x14 error counts.

Top module: `cec_tx_retry_ctrl`

## Requirements
- R1: After reset every register reads 0, and `tx_start`, `tx_byte_valid` and all three flag outputs are low.
- R2: Writing a value with bit 0 set to the enable register (0x12) while idle pulses `tx_start` for one cycle, visible in the cycle after the write. It also clears both error counts, and enable bit 0 reads 1 until the operation ends.
- R3: Each attempt streams frame bytes 0x00 upward, one per accepted handshake. `tx_byte_last` marks the final byte. The count is taken from the length register (0x10): 0 sends 1 byte and values above 16 send 16.
- R4: Each NACK result increments error-count bits [3:0], and each low-drive result increments bits [7:4]. Both fields saturate at 15.
- R5: After failed attempt n (counted from 1), a new attempt starts only if n is at most the retry limit in bits [6:4] of register 0x11. Otherwise the operation ends and sets the retry-timeout flag, bit 3 of 0x13 and `irq_retry_timeout`.
- R6: An acknowledged result ends the operation and sets the ready flag, bit 5 of 0x13 and `irq_ready`.
- R7: An arbitration-lost result ends the operation at once, with no retry, and sets bit 4 of 0x13 and `irq_arb_lost`.
- R8: Enable bit 0 clears itself in the cycle after any of the three outcomes.
- R9: Writes to the enable register while an operation is active are ignored. The counts are not cleared and no extra attempt starts.
- R10: Writing 1 to bits [5:3] of 0x13 clears those flags. If a flag is set and cleared in the same cycle, the set wins.
- R11: If several results are asserted in one cycle, the priority is arbitration lost, then acknowledged, then low-drive, then NACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 5 | Write address |
| reg_wdata | input | 8 | Write data |
| reg_raddr | input | 5 | Read address |
| reg_rdata | output | 8 | Read data (combinational) |
| tx_start | output | 1 | One-cycle attempt start to the transmitter |
| tx_byte | output | 8 | Current frame byte |
| tx_byte_valid | output | 1 | Byte is valid |
| tx_byte_last | output | 1 | Byte is the last of the frame |
| tx_byte_ready | input | 1 | Transmitter accepts the byte |
| res_ack | input | 1 | Attempt acknowledged |
| res_nack | input | 1 | Attempt not acknowledged |
| res_arb_lost | input | 1 | Arbitration lost |
| res_low_drive | input | 1 | Low-drive error in the attempt |
| irq_ready | output | 1 | Ready flag |
| irq_arb_lost | output | 1 | Arbitration-lost flag |
| irq_retry_timeout | output | 1 | Retry-timeout flag |

## Verification
The attempt result that ends an operation can arrive in the same cycle as a software write-one-to-clear of the flag register. The bench provokes this by asserting the final acknowledge and the clear write at the same clock edge, with another flag already pending. It then expects the new flag to survive while the older flag is cleared. A second collision is an enable write that lands while an attempt is waiting for its result. This case is judged by the error counts being preserved and by no extra start pulse being issued.

// File: rtl/cec_txr_pkg.sv
package cec_txr_pkg;

  localparam int ADDR_W = 5;
  localparam int RETRY_W = 3;
  localparam int CNT_W = 4;

  localparam logic [ADDR_W-1:0] A_LEN   = 5'h10;
  localparam logic [ADDR_W-1:0] A_RETRY = 5'h11;
  localparam logic [ADDR_W-1:0] A_EN    = 5'h12;
  localparam logic [ADDR_W-1:0] A_IRQ   = 5'h13;
  localparam logic [ADDR_W-1:0] A_ERR   = 5'h14;

  localparam int B_READY = 5;
  localparam int B_ARB   = 4;
  localparam int B_TMO   = 3;
  localparam int B_RETRY_LO = 4;

  typedef enum logic [1:0] {
    S_IDLE,
    S_START,
    S_STREAM,
    S_WAIT
  } seq_state_t;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (&v) ? v : v + 1'b1;
  endfunction

  function automatic int clamp_len(input logic [7:0] raw, input int max_bytes);
    if (raw == 8'd0) return 1;
    if (int'(raw) > max_bytes) return max_bytes;
    return int'(raw);
  endfunction

  function automatic logic retry_allowed(input logic [RETRY_W:0] used,
                                         input logic [RETRY_W-1:0] lim);
    return used <= {1'b0, lim};
  endfunction

endpackage

// File: rtl/cec_txr_regs.sv
module cec_txr_regs
  import cec_txr_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      waddr,
  input  logic [7:0]             wdata,
  input  logic [ADDR_W-1:0]      raddr,
  output logic [7:0]             rdata,
  input  logic [$clog2(MAX_BYTES)-1:0] byte_idx,
  output logic [DATA_W-1:0]      byte_out,
  output logic [$clog2(MAX_BYTES+1)-1:0] frame_len,
  output logic [RETRY_W-1:0]     retry_lim,
  output logic                   busy,
  output logic                   go,
  input  logic                   done_ok,
  input  logic                   done_arb,
  input  logic                   done_tmo,
  input  logic                   inc_nack,
  input  logic                   inc_low,
  output logic                   flag_ready,
  output logic                   flag_arb,
  output logic                   flag_tmo
);
  localparam int IDX_W = $clog2(MAX_BYTES);
  localparam int LEN_W = $clog2(MAX_BYTES+1);
  localparam logic [ADDR_W-1:0] FRAME_TOP = ADDR_W'(MAX_BYTES);

  logic [DATA_W-1:0]  frame_q [MAX_BYTES];
  logic [7:0]         len_q;
  logic [RETRY_W-1:0] retry_q;
  logic               en_q;
  logic [CNT_W-1:0]   nack_q, low_q;
  logic               rdy_q, arb_q, tmo_q;

  logic wr_frame, wr_len, wr_retry, wr_irq;
  logic done_any;

  assign wr_frame = we && (waddr < FRAME_TOP);
  assign wr_len   = we && (waddr == A_LEN);
  assign wr_retry = we && (waddr == A_RETRY);
  assign wr_irq   = we && (waddr == A_IRQ);
  assign go       = we && (waddr == A_EN) && wdata[0] && !en_q;
  assign done_any = done_ok || done_arb || done_tmo;

  generate
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_frame
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frame_q[g] <= '0;
        else if (wr_frame && (waddr[IDX_W-1:0] == IDX_W'(g)))
          frame_q[g] <= wdata[DATA_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q   <= '0;
      retry_q <= '0;
    end else begin
      if (wr_len)   len_q   <= wdata;
      if (wr_retry) retry_q <= wdata[B_RETRY_LO +: RETRY_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_q <= 1'b0;
    else if (go)       en_q <= 1'b1;
    else if (done_any) en_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nack_q <= '0;
      low_q  <= '0;
    end else if (go) begin
      nack_q <= '0;
      low_q  <= '0;
    end else begin
      if (inc_nack) nack_q <= sat_inc(nack_q);
      if (inc_low)  low_q  <= sat_inc(low_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      arb_q <= 1'b0;
      tmo_q <= 1'b0;
    end else begin
      rdy_q <= done_ok  || (rdy_q && !(wr_irq && wdata[B_READY]));
      arb_q <= done_arb || (arb_q && !(wr_irq && wdata[B_ARB]));
      tmo_q <= done_tmo || (tmo_q && !(wr_irq && wdata[B_TMO]));
    end
  end

  always_comb begin
    rdata = '0;
    if (raddr < FRAME_TOP) rdata = 8'(frame_q[raddr[IDX_W-1:0]]);
    else begin
      unique case (raddr)
        A_LEN:   rdata = len_q;
        A_RETRY: rdata[B_RETRY_LO +: RETRY_W] = retry_q;
        A_EN:    rdata[0] = en_q;
        A_IRQ: begin
          rdata[B_READY] = rdy_q;
          rdata[B_ARB]   = arb_q;
          rdata[B_TMO]   = tmo_q;
        end
        A_ERR:   rdata = {low_q, nack_q};
        default: rdata = '0;
      endcase
    end
  end

  assign byte_out   = frame_q[byte_idx];
  assign frame_len  = LEN_W'(clamp_len(len_q, MAX_BYTES));
  assign retry_lim  = retry_q;
  assign busy       = en_q;
  assign flag_ready = rdy_q;
  assign flag_arb   = arb_q;
  assign flag_tmo   = tmo_q;

  assert_enable_self_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_any |=> !en_q);
  assert_ready_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> rdy_q);
  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_tmo && wr_irq && wdata[B_TMO]) |=> tmo_q);
  assert_counts_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> (nack_q == '0 && low_q == '0));
  assert_nack_monotonic_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !go |=> nack_q >= $past(nack_q));
  assert_busy_start_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !done_any) |=> en_q);

endmodule

// File: rtl/cec_txr_seq.sv
module cec_txr_seq
  import cec_txr_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   go,
  input  logic                   busy,
  input  logic [$clog2(MAX_BYTES+1)-1:0] frame_len,
  input  logic [RETRY_W-1:0]     retry_lim,
  input  logic [DATA_W-1:0]      byte_in,
  output logic [$clog2(MAX_BYTES)-1:0] byte_idx,
  output logic                   tx_start,
  output logic [DATA_W-1:0]      tx_byte,
  output logic                   tx_byte_valid,
  output logic                   tx_byte_last,
  input  logic                   tx_byte_ready,
  input  logic                   res_ack,
  input  logic                   res_nack,
  input  logic                   res_arb_lost,
  input  logic                   res_low_drive,
  output logic                   done_ok,
  output logic                   done_arb,
  output logic                   done_tmo,
  output logic                   inc_nack,
  output logic                   inc_low
);
  localparam int IDX_W = $clog2(MAX_BYTES);
  localparam int LEN_W = $clog2(MAX_BYTES+1);
  localparam int ATT_W = RETRY_W + 1;

  seq_state_t       st_q, st_d;
  logic [IDX_W-1:0] idx_q;
  logic [ATT_W-1:0] att_q;
  logic [ATT_W-1:0] att_next;

  logic in_attempt;
  logic take_arb, take_ack, take_low, take_nack;
  logic failed, retry_ok, last_byte, byte_fire;

  assign in_attempt = (st_q == S_STREAM) || (st_q == S_WAIT);
  assign take_arb   = in_attempt && res_arb_lost;
  assign take_ack   = in_attempt && !res_arb_lost && res_ack;
  assign take_low   = in_attempt && !res_arb_lost && !res_ack && res_low_drive;
  assign take_nack  = in_attempt && !res_arb_lost && !res_ack && !res_low_drive && res_nack;
  assign failed     = take_low || take_nack;
  assign att_next   = att_q + 1'b1;
  assign retry_ok   = retry_allowed(att_next, retry_lim);

  assign last_byte  = (LEN_W'(idx_q) == frame_len - LEN_W'(1));
  assign byte_fire  = (st_q == S_STREAM) && tx_byte_ready;

  assign done_ok  = take_ack;
  assign done_arb = take_arb;
  assign done_tmo = failed && !retry_ok;
  assign inc_nack = take_nack;
  assign inc_low  = take_low;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:   if (go) st_d = S_START;
      S_START:  st_d = S_STREAM;
      S_STREAM: if (byte_fire && last_byte) st_d = S_WAIT;
      S_WAIT:   st_d = S_WAIT;
      default:  st_d = S_IDLE;
    endcase
    if (take_arb || take_ack) st_d = S_IDLE;
    else if (failed) st_d = retry_ok ? S_START : S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      idx_q <= '0;
      att_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == S_IDLE && go) att_q <= '0;
      else if (failed)         att_q <= att_next;
      if (st_q == S_START)                  idx_q <= '0;
      else if (byte_fire && !last_byte)     idx_q <= idx_q + 1'b1;
    end
  end

  assign byte_idx      = idx_q;
  assign tx_start      = (st_q == S_START);
  assign tx_byte_valid = (st_q == S_STREAM);
  assign tx_byte       = byte_in;
  assign tx_byte_last  = tx_byte_valid && last_byte;

  assert_single_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_ok, done_arb, done_tmo, inc_nack && !done_tmo, inc_low && !done_tmo}));
  assert_start_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> busy);
  assert_stream_follows_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> tx_byte_valid);
  assert_no_retry_after_arb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_arb |=> !tx_start);
  assert_retry_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (att_q <= {1'b0, retry_lim}));

endmodule

// File: rtl/cec_tx_retry_ctrl.sv
module cec_tx_retry_ctrl
  import cec_txr_pkg::*;
#(
  parameter int MAX_BYTES = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [4:0]        reg_waddr,
  input  logic [7:0]        reg_wdata,
  input  logic [4:0]        reg_raddr,
  output logic [7:0]        reg_rdata,
  output logic              tx_start,
  output logic [DATA_W-1:0] tx_byte,
  output logic              tx_byte_valid,
  output logic              tx_byte_last,
  input  logic              tx_byte_ready,
  input  logic              res_ack,
  input  logic              res_nack,
  input  logic              res_arb_lost,
  input  logic              res_low_drive,
  output logic              irq_ready,
  output logic              irq_arb_lost,
  output logic              irq_retry_timeout
);
  localparam int IDX_W = $clog2(MAX_BYTES);
  localparam int LEN_W = $clog2(MAX_BYTES+1);

  logic [IDX_W-1:0]   byte_idx;
  logic [DATA_W-1:0]  byte_out;
  logic [LEN_W-1:0]   frame_len;
  logic [RETRY_W-1:0] retry_lim;
  logic busy, go;
  logic done_ok, done_arb, done_tmo, inc_nack, inc_low;

  cec_txr_regs #(.MAX_BYTES(MAX_BYTES), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .rdata(reg_rdata),
    .byte_idx(byte_idx), .byte_out(byte_out),
    .frame_len(frame_len), .retry_lim(retry_lim),
    .busy(busy), .go(go),
    .done_ok(done_ok), .done_arb(done_arb), .done_tmo(done_tmo),
    .inc_nack(inc_nack), .inc_low(inc_low),
    .flag_ready(irq_ready), .flag_arb(irq_arb_lost), .flag_tmo(irq_retry_timeout)
  );

  cec_txr_seq #(.MAX_BYTES(MAX_BYTES), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .go(go), .busy(busy),
    .frame_len(frame_len), .retry_lim(retry_lim),
    .byte_in(byte_out), .byte_idx(byte_idx),
    .tx_start(tx_start), .tx_byte(tx_byte),
    .tx_byte_valid(tx_byte_valid), .tx_byte_last(tx_byte_last),
    .tx_byte_ready(tx_byte_ready),
    .res_ack(res_ack), .res_nack(res_nack),
    .res_arb_lost(res_arb_lost), .res_low_drive(res_low_drive),
    .done_ok(done_ok), .done_arb(done_arb), .done_tmo(done_tmo),
    .inc_nack(inc_nack), .inc_low(inc_low)
  );

endmodule

// File: tb/sim_cec_tx_retry_ctrl.sv
module sim_cec_tx_retry_ctrl;
  localparam int C_ACK = 0, C_NACK = 1, C_ARB = 2, C_LOW = 3, C_ACKNACK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [4:0] reg_waddr = '0, reg_raddr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic tx_start, tx_byte_valid, tx_byte_last;
  logic [7:0] tx_byte;
  logic tx_byte_ready = 1'b1;
  logic res_ack = 0, res_nack = 0, res_arb_lost = 0, res_low_drive = 0;
  logic irq_ready, irq_arb_lost, irq_retry_timeout;

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [7:0] fm [16];

  always #10 clk = ~clk;

  cec_tx_retry_ctrl u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    reg_we = 1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    reg_raddr = a; #1; d = reg_rdata;
  endtask

  task automatic load_frame(input int len_raw, input int seed);
    for (int i = 0; i < 16; i++) begin
      fm[i] = 8'((i * 37 + seed * 11 + 5) & 8'hFF);
      wr(5'(i), fm[i]);
    end
    wr(5'h10, 8'(len_raw));
  endtask

  task automatic drive_res(input int code);
    res_ack       = (code == C_ACK) || (code == C_ACKNACK);
    res_nack      = (code == C_NACK) || (code == C_ACKNACK);
    res_arb_lost  = (code == C_ARB);
    res_low_drive = (code == C_LOW);
  endtask

  // poke: issue enable write while waiting for result; w1c: clear flags in result cycle
  task automatic attempt(input int code, input int exp_len, input bit poke, input bit w1c,
                         output bit saw, output int nbytes);
    logic [7:0] d;
    bit good;
    saw = 0; nbytes = 0; good = 1;
    for (int k = 0; k < 20; k++) begin
      if (tx_start) begin saw = 1; break; end
      @(negedge clk);
    end
    if (!saw) return;
    @(negedge clk);
    for (int k = 0; k < 40; k++) begin
      if (tx_byte_valid) begin
        if (tx_byte !== fm[nbytes]) good = 0;
        if (tx_byte_last !== (nbytes == exp_len - 1)) good = 0;
        nbytes++;
        if (tx_byte_last) begin @(negedge clk); break; end
      end
      @(negedge clk);
    end
    chk(good && nbytes == exp_len, "R3 byte stream", nbytes, exp_len);
    if (poke) begin
      rd(5'h12, d);
      chk(d == 8'h01, "R2 enable reads 1 while active", d, 1);
      wr(5'h12, 8'h01);
      wr(5'h12, 8'h00);
    end
    drive_res(code);
    if (w1c) begin reg_we = 1; reg_waddr = 5'h13; reg_wdata = 8'h38; end
    @(negedge clk);
    reg_we = 0;
    drive_res(-1);
  endtask

  task automatic no_start(input int n, input string req);
    bit seen = 0;
    for (int k = 0; k < n; k++) begin
      if (tx_start) seen = 1;
      @(negedge clk);
    end
    chk(!seen, req, seen, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    bit saw;
    int nb;
    bit all_zero;

    repeat (3) @(negedge clk);
    // R1 reset state
    all_zero = 1;
    for (int a = 0; a < 21; a++) begin
      rd(5'(a), d);
      if (d !== 8'h00) all_zero = 0;
    end
    chk(all_zero && !tx_start && !tx_byte_valid && !irq_ready && !irq_arb_lost && !irq_retry_timeout,
        "R1 reset state", 0, 0);
    rst_n = 1;
    @(negedge clk);

    // Sweep: retry limit 1..7, number of failures 0..limit+1 (R4 R5 R6 R8)
    for (int r = 1; r <= 7; r++) begin
      for (int f = 0; f <= r + 1; f++) begin
        int exp_att, en_n, en_l, lraw, elen;
        bit all_saw;
        logic [7:0] exp_irq;
        lraw = 1 + ((r * 3 + f) % 16);
        elen = lraw;
        wr(5'h13, 8'h38);
        wr(5'h11, 8'(r << 4));
        load_frame(lraw, r * 10 + f);
        wr(5'h12, 8'h01);
        exp_att = (f <= r) ? f + 1 : r + 1;
        en_n = 0; en_l = 0; all_saw = 1;
        for (int a = 0; a < exp_att; a++) begin
          int code;
          if (a < f) code = (((a + r) % 3) == 0) ? C_LOW : C_NACK;
          else code = C_ACK;
          if (code == C_LOW) en_l++;
          if (code == C_NACK) en_n++;
          attempt(code, elen, 0, 0, saw, nb);
          if (!saw) all_saw = 0;
        end
        chk(all_saw, "R5 each permitted attempt started", all_saw, 1);
        no_start(6, "R5 no attempt beyond retry limit");
        rd(5'h12, d);
        chk(d == 8'h00, "R8 enable self-clears", d, 0);
        exp_irq = (f <= r) ? 8'h20 : 8'h08;
        rd(5'h13, d);
        chk(d == exp_irq, (f <= r) ? "R6 ready flag" : "R5 retry-timeout flag", d, exp_irq);
        chk({irq_ready, irq_arb_lost, irq_retry_timeout} == {exp_irq[5], exp_irq[4], exp_irq[3]},
            "R6 flag outputs", {irq_ready, irq_arb_lost, irq_retry_timeout}, {exp_irq[5], exp_irq[4], exp_irq[3]});
        rd(5'h14, d);
        chk(d == 8'((en_l << 4) | en_n), "R4 error counts", d, (en_l << 4) | en_n);
      end
    end

    // R2: start pulse in the cycle after the write, counts cleared (previous run left counts)
    wr(5'h13, 8'h38);
    wr(5'h11, 8'h30);
    load_frame(2, 77);
    reg_we = 1; reg_waddr = 5'h12; reg_wdata = 8'h01;
    @(negedge clk);
    reg_we = 0;
    chk(tx_start === 1'b1, "R2 start pulse after enable write", tx_start, 1);
    rd(5'h14, d);
    chk(d == 8'h00, "R2 counts cleared on start", d, 0);
    // R7: nack then arbitration lost -> stop at once
    attempt(C_NACK, 2, 0, 0, saw, nb);
    attempt(C_ARB, 2, 0, 0, saw, nb);
    chk(saw, "R7 second attempt ran", saw, 1);
    no_start(10, "R7 no retry after arbitration loss");
    rd(5'h13, d);
    chk(d == 8'h10 && irq_arb_lost, "R7 arbitration flag", d, 8'h10);
    rd(5'h14, d);
    chk(d == 8'h01, "R7 counts kept", d, 1);
    rd(5'h12, d);
    chk(d == 8'h00, "R8 enable cleared after arbitration loss", d, 0);

    // R10: ack and clear-write in the same cycle; arb flag pending
    wr(5'h11, 8'h10);
    wr(5'h12, 8'h01);
    attempt(C_ACK, 2, 0, 1, saw, nb);
    rd(5'h13, d);
    chk(d == 8'h20, "R10 set wins over clear, others cleared", d, 8'h20);
    wr(5'h13, 8'h20);
    rd(5'h13, d);
    chk(d == 8'h00 && !irq_ready, "R10 write-one clears ready", d, 0);

    // R9: enable writes while active are ignored
    wr(5'h11, 8'h20);
    load_frame(16, 5);
    wr(5'h12, 8'h01);
    attempt(C_NACK, 16, 0, 0, saw, nb);
    attempt(C_ACK, 16, 1, 0, saw, nb);
    no_start(6, "R9 no extra attempt from busy write");
    rd(5'h14, d);
    chk(d == 8'h01, "R9 counts not cleared by busy write", d, 1);
    rd(5'h13, d);
    chk(d == 8'h20, "R9 operation completed normally", d, 8'h20);

    // R3 length clamping
    wr(5'h13, 8'h38);
    load_frame(0, 9);
    wr(5'h12, 8'h01);
    attempt(C_ACK, 1, 0, 0, saw, nb);
    chk(nb == 1, "R3 zero length sends one byte", nb, 1);
    load_frame(25, 3);
    wr(5'h12, 8'h01);
    attempt(C_ACK, 16, 0, 0, saw, nb);
    chk(nb == 16, "R3 long length clamps to 16", nb, 16);

    // R11: ack and nack together -> ack wins
    wr(5'h13, 8'h38);
    load_frame(3, 4);
    wr(5'h12, 8'h01);
    attempt(C_ACKNACK, 3, 0, 0, saw, nb);
    rd(5'h13, d);
    chk(d == 8'h20, "R11 ack has priority over nack", d, 8'h20);
    rd(5'h14, d);
    chk(d == 8'h00, "R11 nack not counted under ack", d, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule